// File: doc/BRIEF.md
# Prioritized Locality Ownership Arbiter

This block holds the per-locality access register of a shared security coprocessor. Several software localities, numbered from 0 upward with higher numbers carrying higher priority, each see their own byte-wide view of the register. A locality can ask for the device, see whether it holds the device, notice that another locality is waiting, and take the device away from a lower-numbered holder. At most one locality owns the device at any time. The block decides who that is and builds the status byte that each locality reads.

Software talks to the block through a single-cycle write strobe and a combinational read port. Both carry a locality index. Reads have no side effects. The read value for a locality is formed from registered state and two level inputs. One input reports whether the device is fitted. The other reports whether a trusted operating system has been set up. When the device is absent, or the index names a locality that does not exist, the read returns all ones, which host software takes to mean that no device is present.

Top module: `locarb_top`

## Requirements
- R1: For a valid locality on a present device, bit 7 of the read value is 1, and bits 6 and 3 read as 0.
- R2: Bit 5 reads 1 only for the locality that currently owns the device. No more than one locality ever reads it as 1.
- R3: When a locality that does not own the device writes 1 to bit 1, it registers a request, and bit 1 of its own read value shows 1 until that request is granted or cleared. The same write from the current owner is ignored.
- R4: When the device has no owner and requests are outstanding, the highest-numbered requester becomes owner on the next clock edge and its request is cleared. A request written while the device is free therefore shows ownership two cycles after the write.
- R5: When the owner writes 1 to bit 5, the device becomes free on the next edge. The same write from any other locality changes nothing.
- R6: When a locality writes 1 to bit 3 while the device is free or owned by a lower-numbered locality, the writer owns the device after the next edge. The same write from a locality at or below the current owner is ignored.
- R7: A locality that loses ownership through R6 reads bit 4 as 1. The bit stays set across any later activity until that locality writes 1 to bit 4.
- R8: Bit 2 reads 1 for a locality exactly when some other locality has a request outstanding.
- R9: Bit 0 reads as the inverse of the os_established input.
- R10: When dev_present is 0, or the read index is not below NUM_LOC, the read value is 8'hFF. A write with an index that is not below NUM_LOC has no effect.
- R11: If a seize is taken while the device is free, it wins over a pending grant in the same cycle. A seize also clears any request the seizing locality had outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_present | input | 1 | 1 when the coprocessor is fitted |
| os_established | input | 1 | 1 once a trusted OS has been set up |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_loc | input | LOC_W | Locality index of the write |
| wr_data | input | 8 | Write byte: bit1 request, bit3 seize, bit4 clear seized flag, bit5 release |
| rd_loc | input | LOC_W | Locality index of the read |
| rd_data | output | 8 | Access byte for rd_loc |

## Verification
An owner register that is stuck or wrong shows at the ports in the cycle after the faulty edge, because bit 5 of every locality's view is compared against a behavioural model on every clock. A request bit that is lost or left set shows in that locality's bit 1 and in every other locality's bit 2 at the same moment. It then shows a cycle later as the wrong grant winner. A seized flag that is wrongly set or wrongly cleared shows only in the bit 4 of the displaced locality, so each seize scenario is followed by reads of that locality across several later cycles.

// File: rtl/locarb_pkg.sv
// Package: shared widths and bit positions of the access byte.
// Assumes: one byte per locality view; positions below are fixed by software.
package locarb_pkg;
    localparam int ACC_W       = 8;
    localparam int BIT_VALID   = 7;
    localparam int BIT_ACTIVE  = 5;
    localparam int BIT_SEIZED  = 4;
    localparam int BIT_SEIZE   = 3;
    localparam int BIT_PEND    = 2;
    localparam int BIT_REQ     = 1;
    localparam int BIT_NOTEST  = 0;
    localparam logic [ACC_W-1:0] ABSENT_VAL = 8'hFF;
endpackage

// File: rtl/locarb_owner.sv
// Module: locarb_owner
// Holds the owner register and decides between seize, release and grant.
// Assumes: at most one write per cycle; wr_idx is meaningful only when wr_ok.
module locarb_owner #(
    parameter int NUM_LOC = 5,
    parameter int IDX_W   = $clog2(NUM_LOC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               seize_cmd,
    input  logic               release_cmd,
    input  logic [NUM_LOC-1:0] req_vec,
    output logic               own_vld,
    output logic [IDX_W-1:0]   own_idx,
    output logic               seize_take,
    output logic               grant_take,
    output logic [IDX_W-1:0]   grant_idx
);
    logic release_take;

    // Priority pick: the highest-numbered requester wins.
    always_comb begin
        grant_idx = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (req_vec[i]) grant_idx = IDX_W'(i);
        end
    end

    // Decide which ownership event applies this cycle.
    always_comb begin
        seize_take   = wr_ok && seize_cmd && (!own_vld || (own_idx < wr_idx));
        release_take = wr_ok && release_cmd && own_vld && (own_idx == wr_idx);
        grant_take   = !own_vld && !seize_take && (|req_vec);
    end

    // Owner register update: seize, then release, then grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_vld <= 1'b0;
            own_idx <= '0;
        end else if (seize_take) begin
            own_vld <= 1'b1;
            own_idx <= wr_idx;
        end else if (release_take) begin
            own_vld <= 1'b0;
        end else if (grant_take) begin
            own_vld <= 1'b1;
            own_idx <= grant_idx;
        end
    end

    // R6: an accepted seize makes the writer the owner after the edge.
    a_r6_seize_owns: assert property (@(posedge clk) disable iff (!rst_n)
        seize_take |=> (own_vld && own_idx == $past(wr_idx)));

    // R5: the owner's release leaves the device free after the edge.
    a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && release_cmd && own_vld && own_idx == wr_idx) |=> !own_vld);

    // R4: ownership appears only after a pending request or a seize.
    a_r4_grant_from_free: assert property (@(posedge clk) disable iff (!rst_n)
        (own_vld && !$past(own_vld)) |-> ($past(|req_vec) || $past(wr_ok && seize_cmd)));

    // R2: the owner index always names a real locality.
    a_r2_owner_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        own_vld |-> (int'(own_idx) < NUM_LOC));
endmodule

// File: rtl/locarb_flags.sv
// Module: locarb_flags
// Per-locality request and sticky seized flags.
// Assumes: the set and clear vectors are formed by the top; clear wins on requests.
module locarb_flags #(
    parameter int NUM_LOC = 5,
    parameter int IDX_W   = $clog2(NUM_LOC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] req_set,
    input  logic [NUM_LOC-1:0] req_clr,
    input  logic [NUM_LOC-1:0] sz_set,
    input  logic [NUM_LOC-1:0] sz_clr,
    input  logic               own_vld,
    input  logic [IDX_W-1:0]   own_idx,
    output logic [NUM_LOC-1:0] req_q,
    output logic [NUM_LOC-1:0] sz_q
);
    // Request flags: a new request is set, a grant or a seize clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q | req_set) & ~req_clr;
    end

    // Seized flags: set on displacement, cleared only by their own locality.
    always_ff @(posedge clk) begin
        if (!rst_n) sz_q <= '0;
        else        sz_q <= (sz_q & ~sz_clr) | sz_set;
    end

    // R3: the current owner never has a request outstanding.
    a_r3_owner_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        own_vld |-> !((req_q >> own_idx) & 1'b1));

    // R7: a seized flag rises only when a lower owner was displaced.
    a_r7_seized_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sz_q & ~$past(sz_q))) |-> $past(own_vld) && (own_idx != $past(own_idx)));
endmodule

// File: rtl/locarb_readback.sv
// Module: locarb_readback
// Builds the access byte seen by one locality from the registered state.
// Assumes: purely combinational; reads have no side effects.
module locarb_readback
    import locarb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int IDX_W   = $clog2(NUM_LOC),
    parameter int LOC_W   = 4
) (
    input  logic [LOC_W-1:0]   rd_loc,
    input  logic               dev_present,
    input  logic               os_established,
    input  logic               own_vld,
    input  logic [IDX_W-1:0]   own_idx,
    input  logic [NUM_LOC-1:0] req_q,
    input  logic [NUM_LOC-1:0] sz_q,
    output logic [ACC_W-1:0]   rd_data
);
    logic [NUM_LOC-1:0] sel;
    logic               rd_ok;

    // One-hot select of the locality being read.
    always_comb begin
        for (int i = 0; i < NUM_LOC; i++) sel[i] = (int'(rd_loc) == i);
        rd_ok = dev_present && (int'(rd_loc) < NUM_LOC);
    end

    // Assemble the status byte or the absent pattern.
    always_comb begin
        rd_data = ABSENT_VAL;
        if (rd_ok) begin
            rd_data             = '0;
            rd_data[BIT_VALID]  = 1'b1;
            rd_data[BIT_ACTIVE] = own_vld && sel[own_idx];
            rd_data[BIT_SEIZED] = |(sz_q & sel);
            rd_data[BIT_PEND]   = |(req_q & ~sel);
            rd_data[BIT_REQ]    = |(req_q & sel);
            rd_data[BIT_NOTEST] = !os_established;
        end
    end
endmodule

// File: rtl/locarb_top.sv
// Module: locarb_top
// Locality ownership arbiter for a shared coprocessor access register.
// Assumes: one write per cycle; higher locality number has higher priority.
module locarb_top
    import locarb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 4,
    localparam int IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_present,
    input  logic             os_established,
    input  logic             wr_en,
    input  logic [LOC_W-1:0] wr_loc,
    input  logic [ACC_W-1:0] wr_data,
    input  logic [LOC_W-1:0] rd_loc,
    output logic [ACC_W-1:0] rd_data
);
    logic               wr_ok;
    logic [IDX_W-1:0]   wr_idx;
    logic               own_vld;
    logic [IDX_W-1:0]   own_idx;
    logic               seize_take;
    logic               grant_take;
    logic [IDX_W-1:0]   grant_idx;
    logic [NUM_LOC-1:0] req_q, sz_q;
    logic [NUM_LOC-1:0] req_set, req_clr, sz_set, sz_clr;

    // Qualify the write: the index must name a real locality.
    always_comb begin
        wr_ok  = wr_en && (int'(wr_loc) < NUM_LOC);
        wr_idx = IDX_W'(wr_loc);
    end

    // Per-locality set and clear strobes for the flag registers.
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        logic hit, is_own;
        assign hit        = wr_ok && (wr_idx == IDX_W'(g));
        assign is_own     = own_vld && (own_idx == IDX_W'(g));
        assign req_set[g] = hit && wr_data[BIT_REQ] && !seize_take && !is_own;
        assign req_clr[g] = (grant_take && grant_idx == IDX_W'(g)) || (seize_take && hit);
        assign sz_set[g]  = seize_take && is_own;
        assign sz_clr[g]  = hit && wr_data[BIT_SEIZED];
    end

    locarb_owner #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) u_owner (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_idx(wr_idx),
        .seize_cmd(wr_data[BIT_SEIZE]), .release_cmd(wr_data[BIT_ACTIVE]),
        .req_vec(req_q), .own_vld(own_vld), .own_idx(own_idx),
        .seize_take(seize_take), .grant_take(grant_take), .grant_idx(grant_idx)
    );

    locarb_flags #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .sz_set(sz_set), .sz_clr(sz_clr), .own_vld(own_vld), .own_idx(own_idx),
        .req_q(req_q), .sz_q(sz_q)
    );

    locarb_readback #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W), .LOC_W(LOC_W)) u_rd (
        .rd_loc(rd_loc), .dev_present(dev_present), .os_established(os_established),
        .own_vld(own_vld), .own_idx(own_idx), .req_q(req_q), .sz_q(sz_q),
        .rd_data(rd_data)
    );

    // R11: a seize taken while free suppresses the grant of that cycle.
    a_r11_seize_beats_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (seize_take && !own_vld && (|req_q)) |=> (own_idx == $past(wr_idx)));
endmodule

// File: tb/locarb_top_bench.sv
`timescale 1ns/100ps
module locarb_top_bench;
    localparam int N = 5;
    localparam int LW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dev_present = 1'b1, os_established = 1'b0;
    logic wr_en = 1'b0;
    logic [LW-1:0] wr_loc = '0, rd_loc = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int n_checks = 0, n_fail = 0;
    int own_m = -1;
    bit req_m [N];
    bit sz_m  [N];

    always #10 clk = ~clk;

    locarb_top #(.NUM_LOC(N), .LOC_W(LW)) u_locarb_top (
        .clk(clk), .rst_n(rst_n), .dev_present(dev_present),
        .os_established(os_established), .wr_en(wr_en), .wr_loc(wr_loc),
        .wr_data(wr_data), .rd_loc(rd_loc), .rd_data(rd_data)
    );

    task automatic chk(string tag, int loc, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s loc=%0d actual=%02h expected=%02h", tag, loc, act, exp);
        end
    endtask

    // Behavioural model step: state after one edge.
    task automatic model_step(bit we, int l, logic [7:0] d);
        int  nown = own_m;
        bit  nreq [N];
        bit  nsz  [N];
        bit  seized_now = 0;
        bit  any = 0;
        int  hi = -1;
        for (int i = 0; i < N; i++) begin
            nreq[i] = req_m[i];
            nsz[i]  = sz_m[i];
            if (req_m[i]) begin any = 1; hi = i; end
        end
        if (we && l < N) begin
            if (d[3] && (own_m < 0 || own_m < l)) begin
                if (own_m >= 0) nsz[own_m] = 1;
                nown = l;
                seized_now = 1;
            end else if (d[5] && own_m == l) begin
                nown = -1;
            end
            if (d[1] && !seized_now && own_m != l) nreq[l] = 1;
            if (seized_now) nreq[l] = 0;
            if (d[4]) nsz[l] = 0;
        end
        if (own_m < 0 && !seized_now && any) begin
            nown = hi;
            nreq[hi] = 0;
        end
        own_m = nown;
        for (int i = 0; i < N; i++) begin
            req_m[i] = nreq[i];
            sz_m[i]  = nsz[i];
        end
    endtask

    // Compare every locality view (plus two out-of-range ones) with the model.
    task automatic sweep();
        for (int l = 0; l < N + 2; l++) begin
            logic [7:0] e;
            bit others = 0;
            rd_loc = LW'(l);
            #1;
            if (!dev_present || l >= N) begin
                chk("R10", l, rd_data, 8'hFF);
            end else begin
                for (int k = 0; k < N; k++) if (k != l && req_m[k]) others = 1;
                e = {1'b1, 1'b0, own_m == l, sz_m[l], 1'b0, others, req_m[l], !os_established};
                chk("R1",  l, {rd_data[7], rd_data[6], rd_data[3]}, {5'd0, e[7], e[6], e[3]});
                chk("R2",  l, {7'd0, rd_data[5]}, {7'd0, e[5]});
                chk("R7",  l, {7'd0, rd_data[4]}, {7'd0, e[4]});
                chk("R8",  l, {7'd0, rd_data[2]}, {7'd0, e[2]});
                chk("R3",  l, {7'd0, rd_data[1]}, {7'd0, e[1]});
                chk("R9",  l, {7'd0, rd_data[0]}, {7'd0, e[0]});
            end
        end
    endtask

    task automatic step(bit we, int l, logic [7:0] d);
        wr_en = we; wr_loc = LW'(l); wr_data = d;
        @(posedge clk);
        model_step(we, l, d);
        @(negedge clk);
        wr_en = 1'b0;
        sweep();
    endtask

    task automatic expect_owner(string tag, int l);
        rd_loc = LW'(l);
        #1;
        chk(tag, l, {7'd0, rd_data[5]}, 8'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < N; i++) begin req_m[i] = 0; sz_m[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        sweep();                                   // reset state
        // R4: request to a free device, owner two cycles later
        step(1, 1, 8'h02);
        step(0, 0, 8'h00);
        expect_owner("R4", 1);
        // R3: owner's own request ignored
        step(1, 1, 8'h02);
        // R8: others pend
        step(1, 0, 8'h02);
        step(1, 3, 8'h02);
        // R5: non-owner release ignored, owner release frees
        step(1, 0, 8'h20);
        expect_owner("R5", 1);
        step(1, 1, 8'h20);
        step(0, 0, 8'h00);
        expect_owner("R4", 3);                     // highest requester wins
        // R6: lower seize ignored, higher seize takes
        step(1, 2, 8'h08);
        expect_owner("R6", 3);
        step(1, 4, 8'h08);
        expect_owner("R6", 4);
        step(0, 0, 8'h00);
        step(1, 3, 8'h02);
        // R7: sticky until own clear; others cannot clear it
        step(1, 2, 8'h10);
        step(1, 3, 8'h10);
        // R4: release with pending requests
        step(1, 4, 8'h20);
        step(0, 0, 8'h00);
        step(0, 0, 8'h00);
        // R11: seize beats grant while free
        step(1, 1, 8'h02);
        step(1, 3, 8'h20);
        step(1, 2, 8'h08);
        expect_owner("R11", 2);
        step(1, 4, 8'h02);
        step(1, 4, 8'h0A);
        expect_owner("R11", 4);
        // R10: out-of-range write ignored, absent device
        step(1, 6, 8'h08);
        expect_owner("R10", 4);
        dev_present = 1'b0;
        step(0, 0, 8'h00);
        dev_present = 1'b1;
        // R9: establishment flag follows input
        os_established = 1'b1;
        step(0, 0, 8'h00);
        step(1, 4, 8'h20);
        for (int i = 0; i < 4; i++) step(0, 0, 8'h00);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule